// File: doc/BRIEF.md
# Compact Instruction Exception Classifier

This block looks at one 16-bit instruction word of a compact instruction set and decides whether the word raises an exception. A word can be a software interrupt, a breakpoint, an undefined instruction, or an ordinary instruction. The result is registered and appears one cycle after the word is presented. An upstream decode stage offers each word with a valid strobe. The next stage reads a one-hot class vector, together with the 8-bit payload carried by trap and breakpoint words.

Several encodings overlap, and the block settles them in a fixed priority: breakpoint first, then software interrupt, then undefined, then ordinary. Conditional-branch words use a 4-bit condition field. Two values of that field change the class of the word: one makes it undefined and the other makes it a software interrupt. One undefined group is set aside for software use, and the block raises a separate flag for words in that group.

Top module: `eic_classifier`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_class, out_payload and out_reserved are all zero.
- R2: out_valid equals in_valid delayed by one cycle. When out_valid is high, out_class has exactly one bit set. When out_valid is low, out_class is zero. The class bits are: bit0 ordinary, bit1 software interrupt, bit2 breakpoint, bit3 undefined.
- R3: A word with bits[15:8] = 0xDF is classed as a software interrupt (out_class = 4'b0010), and out_payload equals bits[7:0] of that word.
- R4: A word with bits[15:8] = 0xBE is classed as a breakpoint (out_class = 4'b0100), and out_payload equals bits[7:0]. It is never classed as undefined.
- R5: A word whose upper byte matches 10110001, 10110x1x, 101110xx, 10111111 or 11011110 is classed as undefined (4'b1000), with out_payload = 0.
- R6: out_reserved is 1 exactly when the upper byte is 0xDE. For every other word it is 0, including every other undefined word.
- R7: In a conditional-branch word (bits[15:12] = 1101, condition in bits[11:8]), condition 1110 gives undefined and condition 1111 gives software interrupt. Conditions 0000 to 1101 give ordinary.
- R8: Every word not covered by R3 to R7 is ordinary (4'b0001), with out_payload = 0 and out_reserved = 0.
- R9: Bits[7:0] of the word never change the class or the reserved flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Registered result valid |
| out_class | output | 4 | One-hot class (bit0 ordinary, bit1 software interrupt, bit2 breakpoint, bit3 undefined) |
| out_payload | output | 8 | Low byte of a trap or breakpoint word, zero otherwise |
| out_reserved | output | 1 | Undefined word lies in the group reserved for software |

## Verification
The bench tests the neighbours of the breakpoint byte: 0xBC, 0xBD and 0xBF on either side, and 0xB4/0xB5, which fall between the undefined ranges. A mask or priority that is off by one bit would swap breakpoint and undefined, or mark a gap word as undefined. It sweeps the conditional-branch condition field at 0000, 1101, 1110 and 1111, so a decoder that ignored the field would report branches as ordinary. It checks that the reserved flag stays low on 0xBF and the other undefined bytes, and changes the low byte under every class. It also presents words on back-to-back cycles, which would show a result slipping by one cycle.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int CLS_W    = 4;
  localparam int CLS_ORD  = 0;
  localparam int CLS_TRAP = 1;
  localparam int CLS_BRK  = 2;
  localparam int CLS_UND  = 3;

  localparam int OP_W     = 8;
  localparam int NUM_UND  = 5;

  localparam logic [OP_W-1:0] OP_TRAP = 8'hDF;
  localparam logic [OP_W-1:0] OP_BRK  = 8'hBE;
  localparam logic [OP_W-1:0] OP_RESV = 8'hDE;

  localparam logic [3:0] BR_PREFIX   = 4'b1101;
  localparam logic [3:0] BR_COND_UND = 4'b1110;
  localparam logic [3:0] BR_COND_TRP = 4'b1111;

  typedef struct packed {
    logic [OP_W-1:0] mask;
    logic [OP_W-1:0] value;
  } op_pat_t;

  function automatic op_pat_t und_pattern(input int idx);
    op_pat_t p;
    case (idx)
      0:       begin p.mask = 8'hFF; p.value = 8'hB1; end
      1:       begin p.mask = 8'hFA; p.value = 8'hB2; end
      2:       begin p.mask = 8'hFC; p.value = 8'hB8; end
      3:       begin p.mask = 8'hFF; p.value = 8'hBF; end
      default: begin p.mask = 8'hFF; p.value = 8'hDE; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/eic_match.sv
module eic_match
  import eic_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output logic            trap_hit,
  output logic            brk_hit,
  output logic            und_hit,
  output logic            resv_hit
);

  logic [NUM_UND-1:0] und_vec;
  logic               is_branch;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_UND; gi++) begin : g_und
      localparam op_pat_t PAT = und_pattern(gi);
      assign und_vec[gi] = ((op & PAT.mask) == PAT.value);
    end
  endgenerate

  assign is_branch = (op[OP_W-1 -: 4] == BR_PREFIX);

  always_comb begin
    trap_hit = (op == OP_TRAP) || (is_branch && op[3:0] == BR_COND_TRP);
    brk_hit  = (op == OP_BRK);
    und_hit  = (|und_vec) || (is_branch && op[3:0] == BR_COND_UND);
    resv_hit = (op == OP_RESV);
  end

endmodule

// File: rtl/eic_resolve.sv
module eic_resolve
  import eic_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic             trap_hit,
  input  logic             brk_hit,
  input  logic             und_hit,
  input  logic             resv_hit,
  input  logic [IMM_W-1:0] imm,
  output logic [CLS_W-1:0] cls,
  output logic [IMM_W-1:0] payload,
  output logic             reserved
);

  always_comb begin
    cls      = '0;
    payload  = '0;
    reserved = 1'b0;
    if (brk_hit) begin
      cls[CLS_BRK] = 1'b1;
      payload      = imm;
    end else if (trap_hit) begin
      cls[CLS_TRAP] = 1'b1;
      payload       = imm;
    end else if (und_hit) begin
      cls[CLS_UND] = 1'b1;
      reserved     = resv_hit;
    end else begin
      cls[CLS_ORD] = 1'b1;
    end
  end

endmodule

// File: rtl/eic_outreg.sv
module eic_outreg
  import eic_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_valid,
  input  logic [CLS_W-1:0] d_cls,
  input  logic [IMM_W-1:0] d_payload,
  input  logic             d_reserved,
  output logic             q_valid,
  output logic [CLS_W-1:0] q_cls,
  output logic [IMM_W-1:0] q_payload,
  output logic             q_reserved
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid    <= 1'b0;
      q_cls      <= '0;
      q_payload  <= '0;
      q_reserved <= 1'b0;
    end else begin
      q_valid    <= d_valid;
      q_cls      <= d_valid ? d_cls : '0;
      q_payload  <= d_valid ? d_payload : '0;
      q_reserved <= d_valid & d_reserved;
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    d_valid |=> q_valid);
  p_idle_delay_r2: assert property (@(posedge clk) disable iff (rst)
    !d_valid |=> !q_valid);
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> $countones(q_cls) == 1);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> q_cls == '0);

endmodule

// File: rtl/eic_classifier.sv
module eic_classifier
  import eic_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [CLS_W-1:0]  out_class,
  output logic [IMM_W-1:0]  out_payload,
  output logic              out_reserved
);

  localparam int OP_LSB = WORD_W - OP_W;

  logic             trap_hit, brk_hit, und_hit, resv_hit;
  logic [CLS_W-1:0] cls_c;
  logic [IMM_W-1:0] pay_c;
  logic             resv_c;

  eic_match u_match (
    .op       (in_word[WORD_W-1:OP_LSB]),
    .trap_hit (trap_hit),
    .brk_hit  (brk_hit),
    .und_hit  (und_hit),
    .resv_hit (resv_hit)
  );

  eic_resolve #(.IMM_W(IMM_W)) u_resolve (
    .trap_hit (trap_hit),
    .brk_hit  (brk_hit),
    .und_hit  (und_hit),
    .resv_hit (resv_hit),
    .imm      (in_word[IMM_W-1:0]),
    .cls      (cls_c),
    .payload  (pay_c),
    .reserved (resv_c)
  );

  eic_outreg #(.IMM_W(IMM_W)) u_outreg (
    .clk        (clk),
    .rst        (rst),
    .d_valid    (in_valid),
    .d_cls      (cls_c),
    .d_payload  (pay_c),
    .d_reserved (resv_c),
    .q_valid    (out_valid),
    .q_cls      (out_class),
    .q_payload  (out_payload),
    .q_reserved (out_reserved)
  );

  p_brk_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[WORD_W-1:OP_LSB] == OP_BRK) |=>
      (out_class == 4'b0100 && out_payload == $past(in_word[IMM_W-1:0])));
  p_trap_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[WORD_W-1:OP_LSB] == OP_TRAP) |=>
      (out_class == 4'b0010 && out_payload == $past(in_word[IMM_W-1:0])));
  p_resv_r6: assert property (@(posedge clk) disable iff (rst)
    out_reserved |-> (out_valid && out_class[CLS_UND]));
  p_payload_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_class[CLS_UND] || out_class[CLS_ORD]) |-> out_payload == '0);

endmodule

// File: tb/eic_classifier_test.sv
module eic_classifier_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_word;
  logic        out_valid;
  logic [3:0]  out_class;
  logic [7:0]  out_payload;
  logic        out_reserved;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  localparam logic [3:0] C_ORD = 4'b0001;
  localparam logic [3:0] C_TRP = 4'b0010;
  localparam logic [3:0] C_BRK = 4'b0100;
  localparam logic [3:0] C_UND = 4'b1000;

  always #5 clk = ~clk;

  eic_classifier uut (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .out_valid    (out_valid),
    .out_class    (out_class),
    .out_payload  (out_payload),
    .out_reserved (out_reserved)
  );

  task automatic check_out(input string req, input logic v, input logic [3:0] c,
                           input logic [7:0] p, input logic r);
    total++;
    if (out_valid !== v || out_class !== c || out_payload !== p || out_reserved !== r) begin
      bad++;
      $display("FAIL %s: got v=%b cls=%b pay=%h res=%b, want v=%b cls=%b pay=%h res=%b",
               req, out_valid, out_class, out_payload, out_reserved, v, c, p, r);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] w, input logic [3:0] c,
                       input logic [7:0] p, input logic r);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req, 1'b1, c, p, r);
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b1; in_word = 16'hDF12;
    repeat (3) @(negedge clk);
    check_out("R1 during reset", 1'b0, 4'b0000, 8'h00, 1'b0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 after reset", 1'b0, 4'b0000, 8'h00, 1'b0);
  endtask

  task automatic test_trap();
    apply("R3 trap 5A", 16'hDF5A, C_TRP, 8'h5A, 1'b0);
    apply("R3 trap 00 R9", 16'hDF00, C_TRP, 8'h00, 1'b0);
    apply("R3 trap FF R9", 16'hDFFF, C_TRP, 8'hFF, 1'b0);
  endtask

  task automatic test_brk();
    apply("R4 brk 33", 16'hBE33, C_BRK, 8'h33, 1'b0);
    apply("R4 brk C0 R9", 16'hBEC0, C_BRK, 8'hC0, 1'b0);
  endtask

  task automatic test_undef();
    apply("R5 B1", 16'hB1AA, C_UND, 8'h00, 1'b0);
    apply("R5 B2", 16'hB201, C_UND, 8'h00, 1'b0);
    apply("R5 B3", 16'hB3FF, C_UND, 8'h00, 1'b0);
    apply("R5 B6", 16'hB644, C_UND, 8'h00, 1'b0);
    apply("R5 B7", 16'hB790, C_UND, 8'h00, 1'b0);
    apply("R5 B8", 16'hB800, C_UND, 8'h00, 1'b0);
    apply("R5 BB", 16'hBB7E, C_UND, 8'h00, 1'b0);
    apply("R5 BF R6", 16'hBF12, C_UND, 8'h00, 1'b0);
  endtask

  task automatic test_reserved();
    apply("R6 DE 77", 16'hDE77, C_UND, 8'h00, 1'b1);
    apply("R6 DE 00 R9", 16'hDE00, C_UND, 8'h00, 1'b1);
  endtask

  task automatic test_branch();
    apply("R7 cond 0000", 16'hD012, C_ORD, 8'h00, 1'b0);
    apply("R7 cond 1101", 16'hDD80, C_ORD, 8'h00, 1'b0);
    apply("R7 cond 1110", 16'hDE05, C_UND, 8'h00, 1'b1);
    apply("R7 cond 1111", 16'hDF9C, C_TRP, 8'h9C, 1'b0);
  endtask

  task automatic test_ordinary();
    apply("R8 B0", 16'hB0FF, C_ORD, 8'h00, 1'b0);
    apply("R8 B4", 16'hB411, C_ORD, 8'h00, 1'b0);
    apply("R8 B5", 16'hB5F0, C_ORD, 8'h00, 1'b0);
    apply("R8 BC", 16'hBC22, C_ORD, 8'h00, 1'b0);
    apply("R8 BD", 16'hBD01, C_ORD, 8'h00, 1'b0);
    apply("R8 0000", 16'h0000, C_ORD, 8'h00, 1'b0);
    apply("R8 FFFF", 16'hFFFF, C_ORD, 8'h00, 1'b0);
    apply("R8 E000", 16'hE000, C_ORD, 8'h00, 1'b0);
  endtask

  task automatic test_idle_and_stream();
    @(negedge clk);
    check_out("R2 idle", 1'b0, 4'b0000, 8'h00, 1'b0);
    in_valid = 1'b1; in_word = 16'hBE01;
    @(negedge clk);
    check_out("R2 stream 1", 1'b1, C_BRK, 8'h01, 1'b0);
    in_word = 16'hDE02;
    @(negedge clk);
    check_out("R2 stream 2", 1'b1, C_UND, 8'h00, 1'b1);
    in_word = 16'h4403;
    @(negedge clk);
    check_out("R2 stream 3", 1'b1, C_ORD, 8'h00, 1'b0);
    in_valid = 1'b0; in_word = 16'hDF44;
    @(negedge clk);
    check_out("R2 strobe low", 1'b0, 4'b0000, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0;
    in_word  = '0;
    test_reset();
    test_trap();
    test_brk();
    test_undef();
    test_reserved();
    test_branch();
    test_ordinary();
    test_idle_and_stream();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule